// File: doc/BRIEF.md
# Dock Loop Counter and Latch Unit

This unit is the execution datapath of a programmable dock, the element that connects a functional unit to a packet network. It holds three pieces of architectural state: a wide data latch, an outer loop counter, and an inner loop counter with a separate infinity flag. Decoded operations arrive with an execute strobe. Instruction fetch, predicate evaluation and network handshakes happen upstream, so a strobe that reaches this block has already been qualified.

There are three operation classes. A *set* writes a counter or the data latch. A *shift* builds a wide literal by pushing a 19-bit immediate into the bottom of the latch. A *move* is one iteration of data transfer. Each move either captures the incoming word or passes, and it steps the inner counter. An interruptible move is aborted when an interrupt token is present; the token is consumed and both loops end. The counter values and their zero and infinity indications are driven out for the requeue and predicate logic next to this block.

Top module: `dock_ctr_unit`

## Requirements
- R1: After reset, the outer counter is 0, the inner counter is 1 with infinity clear, and the data latch is all zeros.
- R2: A set with destination code 4'b1000 acts on the outer counter, according to the source code. Source 2'b00 loads immediate bits [5:0]. Source 2'b01 loads latch bits [5:0]. Source 2'b10 decrements by one, and a counter already at 0 stays at 0.
- R3: A set with destination 4'b0100 acts on the inner counter. Source 2'b00 loads immediate bits [5:0] and source 2'b01 loads latch bits [5:0]; both clear infinity. Source 2'b10 sets the infinity flag and zeroes the count value.
- R4: A set with destination 4'b0010 loads immediate bits [13:0] into the low 14 latch bits. The upper 23 bits are filled with zeros when the extend bit is 0, and with ones when it is 1.
- R5: A shift (op 2'b10) makes the new latch value {old[17:0], imm[18:0]}.
- R6: A move (op 2'b11) with a finite inner count n ≥ 1 executes (move_go_o high). The count then becomes n-1 if n > 1, and stays at 1 if n = 1. move_done_o is high only when n = 1.
- R7: A move with an inner count of 0 and infinity clear does not execute. It asserts move_done_o, and the inner counter becomes 1.
- R8: A move with infinity set executes, leaves infinity set, and does not assert move_done_o.
- R9: A move with the interruptible bit set while a token is present does not execute. It asserts torp_take_o and move_done_o, forces the outer counter to 0, and sets the inner counter to 1 with infinity clear. A token seen by a move without the interruptible bit has no effect on that move.
- R10: An executing move with the capture bit set loads din_i into the latch. A skipped or aborted move leaves the latch unchanged.
- R11: The following leave all state unchanged: a set whose destination is 4'b0001 (flags, handled elsewhere) or is not one-hot among the three codes above; a counter set with source 2'b11; op 2'b00; and any operation without exec_i.
- R12: olc_zero_o is high exactly when the outer count is 0. ilc_zero_o is high exactly when the inner count is 0 and infinity is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Qualified execute strobe |
| op_i | input | 2 | Operation: 00 none, 01 set, 10 shift, 11 move |
| set_dst_i | input | 4 | One-hot set destination |
| set_src_i | input | 2 | Counter set source: 00 imm, 01 latch, 10 decrement/infinity, 11 hold |
| set_ext_i | input | 1 | Latch set upper fill: 0 zeros, 1 ones |
| imm_i | input | 19 | Immediate field |
| mv_intr_i | input | 1 | Move is interruptible |
| mv_cap_i | input | 1 | Move captures din_i |
| torp_i | input | 1 | Interrupt token present |
| din_i | input | 37 | Incoming data word |
| olc_o | output | 6 | Outer counter value |
| olc_zero_o | output | 1 | Outer counter is zero |
| ilc_o | output | 6 | Inner counter value |
| ilc_zero_o | output | 1 | Inner counter is zero and finite |
| ilc_inf_o | output | 1 | Inner counter is infinite |
| latch_o | output | 37 | Data latch contents |
| move_go_o | output | 1 | Current move executes |
| move_done_o | output | 1 | Current move ends its inner loop |
| torp_take_o | output | 1 | Token consumed by an abort |

## Verification
Every state register is visible at the ports one cycle after the strobe that changes it. A corrupted counter therefore shows up in the next cycle, either in olc_o or ilc_o or in a wrong zero flag. It also shows up in the same cycle as the next move's go and done decisions, which depend on that count. A wrong latch value shows up directly in latch_o, and in any later counter load that takes its source from the latch. The sweeps cover every 6-bit counter value, inner loops of length zero to five, both extend choices, chained shifts, and aborts against both finite and infinite inner counts.

// File: rtl/dock_ctr_pkg.sv
package dock_ctr_pkg;
   typedef enum logic [1:0] {
      OPC_IDLE  = 2'b00,
      OPC_SET   = 2'b01,
      OPC_SHIFT = 2'b10,
      OPC_MOVE  = 2'b11
   } opc_t;

   localparam logic [3:0] DST_OUTER = 4'b1000;
   localparam logic [3:0] DST_INNER = 4'b0100;
   localparam logic [3:0] DST_LATCH = 4'b0010;
   localparam logic [3:0] DST_FLAGS = 4'b0001;

   localparam logic [1:0] SRC_IMM     = 2'b00;
   localparam logic [1:0] SRC_LATCH   = 2'b01;
   localparam logic [1:0] SRC_SPECIAL = 2'b10;
   localparam logic [1:0] SRC_HOLD    = 2'b11;
endpackage

// File: rtl/dock_outer_ctr.sv
module dock_outer_ctr #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          dec_i,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] ZERO = '0;
   localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] cnt_q;

   generate
      if (CW < 1) begin : g_bad_cw
         $error("dock_outer_ctr: CW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                       cnt_q <= ZERO;
      else if (clear_i)                 cnt_q <= ZERO;
      else if (load_i)                  cnt_q <= load_val_i;
      else if (dec_i && cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
   end

   assign cnt_o = cnt_q;

   // R2
   olc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i && !clear_i && !load_i && cnt_q == ZERO |=> cnt_q == ZERO);
   // R2
   olc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i && !clear_i && !load_i && cnt_q != ZERO |=> cnt_q == $past(cnt_q) - ONE);
   // R9
   olc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> cnt_q == ZERO);
endmodule

// File: rtl/dock_inner_ctr.sv
module dock_inner_ctr #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          force_one_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          inf_set_i,
   input  logic          step_i,
   output logic [CW-1:0] cnt_o,
   output logic          inf_o
);
   localparam logic [CW-1:0] ZERO = '0;
   localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

   logic [CW-1:0] cnt_q;
   logic          inf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ONE;
         inf_q <= 1'b0;
      end else if (force_one_i) begin
         cnt_q <= ONE;
         inf_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         inf_q <= 1'b0;
      end else if (inf_set_i) begin
         cnt_q <= ZERO;
         inf_q <= 1'b1;
      end else if (step_i && !inf_q) begin
         cnt_q <= (cnt_q > ONE) ? cnt_q - ONE : ONE;
      end
   end

   assign cnt_o = cnt_q;
   assign inf_o = inf_q;

   // R8
   inf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && inf_q && !force_one_i && !load_i |=> inf_q);
   // R6
   ilc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !inf_q && cnt_q > ONE && !force_one_i && !load_i && !inf_set_i
      |=> cnt_q == $past(cnt_q) - ONE);
   // R9
   ilc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_one_i |=> cnt_q == ONE && !inf_q);
endmodule

// File: rtl/dock_data_latch.sv
module dock_data_latch #(
   parameter int DW  = 37,
   parameter int SHW = 19,
   parameter int LW  = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cap_i,
   input  logic [DW-1:0]  din_i,
   input  logic           set_i,
   input  logic           ext_i,
   input  logic           shift_i,
   input  logic [SHW-1:0] imm_i,
   output logic [DW-1:0]  q_o
);
   logic [DW-1:0] q;
   logic [DW-1:0] set_val;
   logic [DW-1:0] shift_val;

   generate
      if (LW < DW) begin : g_fill
         assign set_val = {{(DW-LW){ext_i}}, imm_i[LW-1:0]};
      end else begin : g_nofill
         assign set_val = imm_i[DW-1:0];
      end
      if (SHW < DW) begin : g_shift
         assign shift_val = {q[DW-SHW-1:0], imm_i};
      end else begin : g_bad_shw
         $error("dock_data_latch: SHW must be below DW");
      end
      if (LW > SHW) begin : g_bad_lw
         $error("dock_data_latch: LW must not exceed SHW");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (cap_i)   q <= din_i;
      else if (set_i)   q <= set_val;
      else if (shift_i) q <= shift_val;
   end

   assign q_o = q;

   // R5
   shift_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i && !cap_i && !set_i |=> q[SHW-1:0] == $past(imm_i));
   // R5
   shift_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i && !cap_i && !set_i |=> q[DW-1:SHW] == $past(q[DW-SHW-1:0]));
   // R4
   set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i && !cap_i |=> q[LW-1:0] == $past(imm_i[LW-1:0]));
endmodule

// File: rtl/dock_ctr_unit.sv
module dock_ctr_unit
   import dock_ctr_pkg::*;
#(
   parameter int DW  = 37,
   parameter int CW  = 6,
   parameter int SHW = 19,
   parameter int LW  = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           exec_i,
   input  logic [1:0]     op_i,
   input  logic [3:0]     set_dst_i,
   input  logic [1:0]     set_src_i,
   input  logic           set_ext_i,
   input  logic [SHW-1:0] imm_i,
   input  logic           mv_intr_i,
   input  logic           mv_cap_i,
   input  logic           torp_i,
   input  logic [DW-1:0]  din_i,
   output logic [CW-1:0]  olc_o,
   output logic           olc_zero_o,
   output logic [CW-1:0]  ilc_o,
   output logic           ilc_zero_o,
   output logic           ilc_inf_o,
   output logic [DW-1:0]  latch_o,
   output logic           move_go_o,
   output logic           move_done_o,
   output logic           torp_take_o
);
   localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

   generate
      if (CW > SHW || CW > DW) begin : g_bad_cw
         $error("dock_ctr_unit: CW must fit in the immediate and the latch");
      end
   endgenerate

   opc_t opc;
   logic is_set, is_shift, is_move, abort;
   logic dst_outer, dst_inner, dst_latch;
   logic src_load;
   logic [CW-1:0] ctr_val;

   assign opc      = opc_t'(op_i);
   assign is_set   = exec_i && opc == OPC_SET;
   assign is_shift = exec_i && opc == OPC_SHIFT;
   assign is_move  = exec_i && opc == OPC_MOVE;
   assign abort    = is_move && mv_intr_i && torp_i;

   assign dst_outer = is_set && set_dst_i == DST_OUTER;
   assign dst_inner = is_set && set_dst_i == DST_INNER;
   assign dst_latch = is_set && set_dst_i == DST_LATCH;
   assign src_load  = set_src_i == SRC_IMM || set_src_i == SRC_LATCH;
   assign ctr_val   = (set_src_i == SRC_LATCH) ? latch_o[CW-1:0] : imm_i[CW-1:0];

   assign move_go_o   = is_move && !abort && (ilc_inf_o || ilc_o != '0);
   assign move_done_o = is_move && (abort || (!ilc_inf_o && ilc_o <= ONE));
   assign torp_take_o = abort;

   dock_outer_ctr #(.CW(CW)) u_outer (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (abort),
      .load_i     (dst_outer && src_load),
      .load_val_i (ctr_val),
      .dec_i      (dst_outer && set_src_i == SRC_SPECIAL),
      .cnt_o      (olc_o)
   );

   dock_inner_ctr #(.CW(CW)) u_inner (
      .clk         (clk),
      .rst_n       (rst_n),
      .force_one_i (abort),
      .load_i      (dst_inner && src_load),
      .load_val_i  (ctr_val),
      .inf_set_i   (dst_inner && set_src_i == SRC_SPECIAL),
      .step_i      (is_move && !abort),
      .cnt_o       (ilc_o),
      .inf_o       (ilc_inf_o)
   );

   dock_data_latch #(.DW(DW), .SHW(SHW), .LW(LW)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (move_go_o && mv_cap_i),
      .din_i   (din_i),
      .set_i   (dst_latch),
      .ext_i   (set_ext_i),
      .shift_i (is_shift),
      .imm_i   (imm_i),
      .q_o     (latch_o)
   );

   assign olc_zero_o = olc_o == '0;
   assign ilc_zero_o = ilc_o == '0 && !ilc_inf_o;

   // R7
   skip_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_move && !abort && ilc_zero_o |=> ilc_o == ONE && !ilc_inf_o);
   // R10
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      move_go_o && mv_cap_i |=> latch_o == $past(din_i));
   // R10
   skip_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_move && !move_go_o |=> $stable(latch_o));
   // R11
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(olc_o) && $stable(ilc_o) && $stable(ilc_inf_o) && $stable(latch_o));
   // R9
   abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      torp_take_o |-> move_done_o && !move_go_o);
endmodule

// File: tb/dock_ctr_unit_test.sv
`timescale 1ns/1ps
module dock_ctr_unit_test;
   localparam logic [1:0] OP_IDLE = 2'b00, OP_SET = 2'b01, OP_SHIFT = 2'b10, OP_MOVE = 2'b11;
   localparam logic [3:0] D_OUT = 4'b1000, D_IN = 4'b0100, D_LAT = 4'b0010, D_FLG = 4'b0001;
   localparam logic [1:0] S_IMM = 2'b00, S_LAT = 2'b01, S_SPC = 2'b10, S_HLD = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [1:0]  op_i = '0;
   logic [3:0]  set_dst_i = '0;
   logic [1:0]  set_src_i = '0;
   logic        set_ext_i = 1'b0;
   logic [18:0] imm_i = '0;
   logic        mv_intr_i = 1'b0, mv_cap_i = 1'b0, torp_i = 1'b0;
   logic [36:0] din_i = '0;
   logic [5:0]  olc_o, ilc_o;
   logic        olc_zero_o, ilc_zero_o, ilc_inf_o, move_go_o, move_done_o, torp_take_o;
   logic [36:0] latch_o;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   logic [5:0]  m_olc = 6'd0;
   logic [5:0]  m_ilc = 6'd1;
   logic        m_inf = 1'b0;
   logic [36:0] m_lat = '0;

   always #2.5 clk = ~clk;

   dock_ctr_unit uut (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .set_dst_i(set_dst_i),
      .set_src_i(set_src_i), .set_ext_i(set_ext_i), .imm_i(imm_i), .mv_intr_i(mv_intr_i),
      .mv_cap_i(mv_cap_i), .torp_i(torp_i), .din_i(din_i), .olc_o(olc_o),
      .olc_zero_o(olc_zero_o), .ilc_o(ilc_o), .ilc_zero_o(ilc_zero_o), .ilc_inf_o(ilc_inf_o),
      .latch_o(latch_o), .move_go_o(move_go_o), .move_done_o(move_done_o),
      .torp_take_o(torp_take_o)
   );

   task automatic chk(input string tag, input string what, input logic [36:0] act, input logic [36:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_state(input string tag);
      chk(tag, "olc", {31'd0, olc_o}, {31'd0, m_olc});
      chk(tag, "ilc", {31'd0, ilc_o}, {31'd0, m_ilc});
      chk(tag, "inf", {36'd0, ilc_inf_o}, {36'd0, m_inf});
      chk(tag, "latch", latch_o, m_lat);
      // R12
      chk(tag, "olc_zero R12", {36'd0, olc_zero_o}, {36'd0, m_olc == 6'd0});
      chk(tag, "ilc_zero R12", {36'd0, ilc_zero_o}, {36'd0, m_ilc == 6'd0 && !m_inf});
   endtask

   task automatic step(input string tag, input logic ex, input logic [1:0] op,
                       input logic [3:0] dst, input logic [1:0] src, input logic ext,
                       input logic [18:0] imm, input logic intr, input logic torp,
                       input logic cap, input logic [36:0] din);
      logic ab, go, done;
      @(negedge clk);
      exec_i = ex; op_i = op; set_dst_i = dst; set_src_i = src; set_ext_i = ext;
      imm_i = imm; mv_intr_i = intr; torp_i = torp; mv_cap_i = cap; din_i = din;
      #1;
      ab   = ex && op == OP_MOVE && intr && torp;
      go   = ex && op == OP_MOVE && !ab && (m_inf || m_ilc != 6'd0);
      done = ex && op == OP_MOVE && (ab || (!m_inf && m_ilc <= 6'd1));
      chk(tag, "move_go", {36'd0, move_go_o}, {36'd0, go});
      chk(tag, "move_done", {36'd0, move_done_o}, {36'd0, done});
      chk(tag, "torp_take", {36'd0, torp_take_o}, {36'd0, ab});
      if (ex) begin
         case (op)
            OP_SET: begin
               if (dst == D_OUT) begin
                  if (src == S_IMM) m_olc = imm[5:0];
                  else if (src == S_LAT) m_olc = m_lat[5:0];
                  else if (src == S_SPC && m_olc != 6'd0) m_olc = m_olc - 6'd1;
               end else if (dst == D_IN) begin
                  if (src == S_IMM) begin m_ilc = imm[5:0]; m_inf = 1'b0; end
                  else if (src == S_LAT) begin m_ilc = m_lat[5:0]; m_inf = 1'b0; end
                  else if (src == S_SPC) begin m_ilc = 6'd0; m_inf = 1'b1; end
               end else if (dst == D_LAT) begin
                  m_lat = {{23{ext}}, imm[13:0]};
               end
            end
            OP_SHIFT: m_lat = {m_lat[17:0], imm};
            OP_MOVE: begin
               if (ab) begin
                  m_olc = 6'd0; m_ilc = 6'd1; m_inf = 1'b0;
               end else begin
                  if (go && cap) m_lat = din;
                  if (!m_inf) m_ilc = (m_ilc > 6'd1) ? m_ilc - 6'd1 : 6'd1;
               end
            end
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      exec_i = 1'b0;
      chk_state(tag);
   endtask

   task automatic set_ctr(input string tag, input logic [3:0] dst, input logic [1:0] src, input logic [18:0] imm);
      step(tag, 1'b1, OP_SET, dst, src, 1'b0, imm, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic mv(input string tag, input logic intr, input logic torp, input logic cap, input logic [36:0] din);
      step(tag, 1'b1, OP_MOVE, 4'b0000, S_HLD, 1'b0, '0, intr, torp, cap, din);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1 reset state
      chk_state("R1");

      // R2 outer loads over every value, then decrement to and past zero
      for (int v = 0; v < 64; v++) set_ctr("R2", D_OUT, S_IMM, 19'(v) | 19'h7FFC0);
      set_ctr("R2", D_OUT, S_IMM, 19'd4);
      for (int k = 0; k < 7; k++) set_ctr("R2", D_OUT, S_SPC, '0);
      step("R4", 1'b1, OP_SET, D_LAT, S_IMM, 1'b0, 19'h02A5, 1'b0, 1'b0, 1'b0, '0);
      set_ctr("R2", D_OUT, S_LAT, '0);

      // R3 inner loads, infinity, load from latch
      for (int v = 0; v < 64; v++) set_ctr("R3", D_IN, S_IMM, 19'(v));
      set_ctr("R3", D_IN, S_SPC, '0);
      set_ctr("R3", D_IN, S_LAT, '0);
      set_ctr("R3", D_IN, S_SPC, '0);
      set_ctr("R3", D_IN, S_IMM, 19'd9);

      // R4 latch set with both fills
      for (int e = 0; e < 2; e++) begin
         step("R4", 1'b1, OP_SET, D_LAT, S_IMM, e[0], 19'h7ABCD, 1'b0, 1'b0, 1'b0, '0);
         step("R4", 1'b1, OP_SET, D_LAT, S_HLD, e[0], 19'h03FFF, 1'b0, 1'b0, 1'b0, '0);
         step("R4", 1'b1, OP_SET, D_LAT, S_IMM, e[0], 19'h00000, 1'b0, 1'b0, 1'b0, '0);
      end

      // R5 chained shifts
      step("R5", 1'b1, OP_SHIFT, 4'b0000, S_IMM, 1'b0, 19'h5A5A5, 1'b0, 1'b0, 1'b0, '0);
      step("R5", 1'b1, OP_SHIFT, 4'b0000, S_IMM, 1'b0, 19'h7FFFF, 1'b0, 1'b0, 1'b0, '0);
      step("R5", 1'b1, OP_SHIFT, 4'b0000, S_IMM, 1'b0, 19'h12345, 1'b0, 1'b0, 1'b0, '0);
      step("R5", 1'b1, OP_SHIFT, 4'b0000, S_IMM, 1'b0, 19'h00001, 1'b0, 1'b0, 1'b0, '0);

      // R6 R7 inner loops of length 0..5, capturing each iteration (R10)
      for (int n = 0; n < 6; n++) begin
         set_ctr("R6", D_IN, S_IMM, 19'(n));
         for (int it = 0; it < ((n == 0) ? 1 : n); it++)
            mv((n == 0) ? "R7" : "R6", 1'b0, 1'b0, 1'b1, 37'h1_2345_6700 + 37'(n * 16 + it));
         mv("R6", 1'b0, 1'b0, 1'b0, '0);
      end
      // R7 skipped move leaves latch alone despite capture
      set_ctr("R7", D_IN, S_IMM, 19'd0);
      mv("R10", 1'b0, 1'b0, 1'b1, 37'h0F0F0F0F0F);

      // R8 infinite inner loop, then abort (R9)
      set_ctr("R2", D_OUT, S_IMM, 19'd7);
      set_ctr("R8", D_IN, S_SPC, '0);
      for (int k = 0; k < 5; k++) mv("R8", 1'b0, 1'b0, 1'b1, 37'h1F0000000 + 37'(k));
      mv("R9", 1'b0, 1'b1, 1'b1, 37'h0AAAAAAAA);
      mv("R9", 1'b1, 1'b1, 1'b1, 37'h055555555);
      mv("R9", 1'b1, 1'b0, 1'b0, '0);
      // R9 abort during a finite loop
      set_ctr("R2", D_OUT, S_IMM, 19'd3);
      set_ctr("R9", D_IN, S_IMM, 19'd4);
      mv("R9", 1'b1, 1'b0, 1'b0, '0);
      mv("R9", 1'b1, 1'b1, 1'b1, 37'h1FFFFFFFFF);

      // R11 operations that must not change state
      set_ctr("R2", D_OUT, S_IMM, 19'd21);
      set_ctr("R3", D_IN, S_IMM, 19'd13);
      set_ctr("R11", D_FLG, S_IMM, 19'h7FFFF);
      set_ctr("R11", 4'b1100, S_IMM, 19'd2);
      set_ctr("R11", 4'b0000, S_SPC, 19'd2);
      set_ctr("R11", D_OUT, S_HLD, 19'd2);
      set_ctr("R11", D_IN, S_HLD, 19'd2);
      step("R11", 1'b1, OP_IDLE, D_OUT, S_IMM, 1'b1, 19'h7FFFF, 1'b1, 1'b1, 1'b1, '1);
      step("R11", 1'b0, OP_SET, D_OUT, S_IMM, 1'b1, 19'd0, 1'b0, 1'b0, 1'b0, '0);
      step("R11", 1'b0, OP_SHIFT, 4'b0000, S_IMM, 1'b0, 19'h7FFFF, 1'b0, 1'b0, 1'b0, '0);
      step("R11", 1'b0, OP_MOVE, 4'b0000, S_IMM, 1'b0, '0, 1'b1, 1'b1, 1'b1, '1);

      // R1 reset again from non-reset state
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      m_olc = 6'd0; m_ilc = 6'd1; m_inf = 1'b0; m_lat = '0;
      chk_state("R1");

      finish_run();
   end
endmodule